// File: doc/BRIEF.md
# Modulo Timer PWM Channel

This block is a 16-bit up-counter that counts on ticks of a prescaler driven from the bus clock. The counter wraps to zero after it reaches a programmable modulo value. One output-compare channel turns each counter period into a pulse. The pin goes to its active level when the counter wraps and returns to its inactive level when the counter reaches the channel value. A polarity bit selects whether the pulse is high-going or low-going.

The channel compare register has no shadow copy, so a write takes effect on the next clock. A badly timed write can skip a compare, or it can produce a second compare in the same period. The block keeps both effects on purpose. It raises sticky overflow and compare flags, each with an interrupt enable, so that software can choose a safe moment to update the channel value. A small register write port loads the control, modulo and channel registers. A counter-reset strobe restarts the period.

Top module: `mtp_pwm_timer`

## Requirements
- R1: While reset is held, `cnt_val` is 0, `pwm_out` is 0, and both flags and both interrupt outputs are 0.
- R2: A write with `wr_sel` 0 loads the control register, 1 loads the modulo register and 2 loads the channel register. The control fields are: bits [2:0] prescaler select, bit 3 polarity, bit 4 overflow interrupt enable, bit 5 compare interrupt enable. A write with `wr_sel` 3 changes nothing.
- R3: The prescaler divides the bus clock by 2^code for codes 0 to 6, and code 7 divides by 64. A `cnt_rst` strobe is applied at one clock edge. After k further edges, `cnt_val` equals floor(k/div) mod (modulo+1).
- R4: The counter steps from the modulo value to 0 on a tick. If the modulo is lowered below the current count, the counter goes to 0 on the next tick.
- R5: The pin becomes active at each wrap and becomes inactive on the tick where the count becomes equal to the channel value. A compare at the wrap wins over the overflow. Once one wrap has occurred under a fixed setup, the pin is active exactly when `cnt_val` < channel. A channel value of 0 never gives an active pin, and a channel value above the modulo keeps the pin always active.
- R6: With polarity 0 the active level is 1 and the inactive level is 0. With polarity 1 both levels are inverted.
- R7: A channel write applies on the next clock. If the new value is below the current count and the old value has not yet been reached, there is no compare until the next period.
- R8: A channel value raised above the count after that period's compare produces a second compare event in the same period.
- R9: Each flag is set by its event and cleared by its clear strobe. If an event and a clear arrive in the same cycle, the flag is set.
- R10: Each interrupt output equals its flag gated by its enable bit.
- R11: `cnt_rst` clears the counter and the prescaler, leaves the modulo and channel values unchanged, and suppresses events in that cycle.
- R12: The count holds its value on every cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 modulo, 2 channel |
| wr_data | input | 16 | Write data |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| cmp_clr | input | 1 | Clear strobe for the compare flag |
| cnt_rst | input | 1 | Clears the counter and the prescaler |
| pwm_out | output | 1 | PWM pin |
| cnt_val | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The assertions check, on every cycle, the local step rules:
- the count holds between ticks and advances by exactly one on a tick that is not a wrap;
- the count reads zero after a wrap or a counter reset;
- the pin reaches the correct level after each compare or overflow event;
- each flag follows its event;
- an interrupt never fires without its flag.

Some behaviour only the bench's scenarios can show:
- the exact period and duty cycle for every prescaler code and channel value;
- the missed compare after a low channel write;
- the double compare after a late high write;
- the wrap from above a lowered modulo;
- that a write with `wr_sel` 3 is ignored.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam int CNT_W = 16;
  localparam int PSC_W = 6;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_CHAN = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Packed so that psel sits in bits [2:0], pol in bit 3, ovf_ie in bit 4, cmp_ie in bit 5
  typedef struct packed {
    logic       cmp_ie;
    logic       ovf_ie;
    logic       pol;
    logic [2:0] psel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // A tick is issued when all bits of the mask are set in the free-running prescaler
  function automatic logic [PSC_W-1:0] div_mask(input logic [2:0] sel);
    logic [PSC_W:0] span;
    span = (PSC_W+1)'(1) << ((sel == 3'd7) ? 3'd6 : sel);
    return PSC_W'(span - (PSC_W+1)'(1));
  endfunction

  function automatic logic is_wrap(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] modv);
    return cnt >= modv;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic wrap);
    return wrap ? '0 : cnt + CNT_W'(1);
  endfunction
endpackage

// File: rtl/mtp_prescaler.sv
module mtp_prescaler
  import mtp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;

  always_comb begin
    mask = div_mask(sel);
    tick = (psc_q & mask) == mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   psc_q <= '0;
    else if (clr) psc_q <= '0;
    else          psc_q <= psc_q + PSC_W'(1);
  end
endmodule

// File: rtl/mtp_counter.sv
module mtp_counter
  import mtp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] modv,
  input  logic [CNT_W-1:0] chan,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_ev,
  output logic             cmp_ev
);
  logic             wrap;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    wrap    = is_wrap(cnt_q, modv);
    cnt_nxt = next_count(cnt_q, wrap);
    ovf_ev  = tick && !clr && wrap;
    cmp_ev  = tick && !clr && (cnt_nxt == chan);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/mtp_chan_out.sv
module mtp_chan_out (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_ev,
  input  logic cmp_ev,
  input  logic pol,
  input  logic ovf_ie,
  input  logic cmp_ie,
  input  logic ovf_clr,
  input  logic cmp_clr,
  output logic pwm_out,
  output logic ovf_flag,
  output logic cmp_flag,
  output logic ovf_irq,
  output logic cmp_irq
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (cmp_ev)      act_q <= 1'b0;
      else if (ovf_ev) act_q <= 1'b1;
      ovf_flag <= ovf_ev | (ovf_flag & ~ovf_clr);
      cmp_flag <= cmp_ev | (cmp_flag & ~cmp_clr);
    end
  end

  always_comb begin
    pwm_out = act_q ? ~pol : pol;
    ovf_irq = ovf_flag & ovf_ie;
    cmp_irq = cmp_flag & cmp_ie;
  end
endmodule

// File: rtl/mtp_pwm_timer.sv
module mtp_pwm_timer
  import mtp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_clr,
  input  logic             cmp_clr,
  input  logic             cnt_rst,
  output logic             pwm_out,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_flag,
  output logic             cmp_flag,
  output logic             ovf_irq,
  output logic             cmp_irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] chan_q;
  logic             tick;
  logic             ovf_ev;
  logic             cmp_ev;
  logic             pol_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mod_q  <= '1;
      chan_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_CTRL: ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        SEL_MOD:  mod_q  <= wr_data;
        SEL_CHAN: chan_q <= wr_data;
        default:  ;
      endcase
    end
  end

  assign pol_w = ctrl_q.pol;

  mtp_prescaler u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_rst),
    .sel   (ctrl_q.psel),
    .tick  (tick)
  );

  mtp_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_rst),
    .tick   (tick),
    .modv   (mod_q),
    .chan   (chan_q),
    .cnt_q  (cnt_val),
    .ovf_ev (ovf_ev),
    .cmp_ev (cmp_ev)
  );

  mtp_chan_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_ev   (ovf_ev),
    .cmp_ev   (cmp_ev),
    .pol      (pol_w),
    .ovf_ie   (ctrl_q.ovf_ie),
    .cmp_ie   (ctrl_q.cmp_ie),
    .ovf_clr  (ovf_clr),
    .cmp_clr  (cmp_clr),
    .pwm_out  (pwm_out),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag),
    .ovf_irq  (ovf_irq),
    .cmp_irq  (cmp_irq)
  );
endmodule

// File: rtl/mtp_pwm_timer_chk.sv
module mtp_pwm_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cnt_rst,
  input logic        tick,
  input logic        ovf_ev,
  input logic        cmp_ev,
  input logic        pol_w,
  input logic [15:0] cnt_val,
  input logic        pwm_out,
  input logic        ovf_flag,
  input logic        cmp_flag,
  input logic        ovf_irq,
  input logic        cmp_irq
);
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_rst) |=> $stable(cnt_val));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_rst && !ovf_ev) |=> (cnt_val == $past(cnt_val) + 16'd1));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (cnt_val == 16'd0));

  // R11
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> (cnt_val == 16'd0));

  // R5
  cmp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ev |=> (pwm_out == pol_w));

  // R6
  ovf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !cmp_ev) |=> (pwm_out != pol_w));

  // R9
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_flag);

  // R9
  cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ev |=> cmp_flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag |-> !ovf_irq) and (!cmp_flag |-> !cmp_irq));
endmodule

bind mtp_pwm_timer mtp_pwm_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_rst  (cnt_rst),
  .tick     (tick),
  .ovf_ev   (ovf_ev),
  .cmp_ev   (cmp_ev),
  .pol_w    (pol_w),
  .cnt_val  (cnt_val),
  .pwm_out  (pwm_out),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag),
  .ovf_irq  (ovf_irq),
  .cmp_irq  (cmp_irq)
);

// File: tb/mtp_pwm_timer_tb.sv
module mtp_pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        ovf_clr = 1'b0;
  logic        cmp_clr = 1'b0;
  logic        cnt_rst = 1'b0;
  logic        pwm_out;
  logic [15:0] cnt_val;
  logic        ovf_flag, cmp_flag, ovf_irq, cmp_irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mtp_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .cnt_rst(cnt_rst), .pwm_out(pwm_out),
    .cnt_val(cnt_val), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All strobe tasks are called at a negedge and return at the next negedge
  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_rst();
    cnt_rst = 1'b1;
    @(negedge clk);
    cnt_rst = 1'b0;
  endtask

  task automatic clr_flags(input logic o, input logic c);
    ovf_clr = o; cmp_clr = c;
    @(negedge clk);
    ovf_clr = 1'b0; cmp_clr = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    while (cnt_val != 16'(v)) @(negedge clk);
  endtask

  // Sweep one setup: exact count sequence, then the duty pattern after the first wrap
  task automatic run_cfg(input int m, input int c, input int ps, input int pl);
    int dv;
    int span;
    logic exp_pin;
    dv   = 1 << ((ps == 7) ? 6 : ps);
    span = (m + 1) * dv;
    wr(2'd0, 16'(ps | (pl << 3)));
    wr(2'd1, 16'(m));
    wr(2'd2, 16'(c));
    pulse_rst();
    for (int k = 0; k < 2 * span; k++) begin
      check("R3 R4 R11 R12 count", 32'(cnt_val), 32'((k / dv) % (m + 1)));
      if (k >= span) begin
        exp_pin = (int'(cnt_val) < c) ? ~pl[0] : pl[0];
        check("R5 R6 pin", 32'(pwm_out), 32'(exp_pin));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL WDOG run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cnt", 32'(cnt_val), 32'd0);
    check("R1 pin", 32'(pwm_out), 32'd0);
    check("R1 flags", 32'({ovf_flag, cmp_flag, ovf_irq, cmp_irq}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep of small modulo values, every channel value, the low prescaler codes, both polarities
    for (int m = 3; m <= 5; m += 2)
      for (int c = 0; c <= m + 1; c++)
        for (int ps = 0; ps <= 2; ps++)
          for (int pl = 0; pl <= 1; pl++)
            run_cfg(m, c, ps, pl);
    // R3 the high prescaler codes, code 7 included
    for (int ps = 3; ps <= 7; ps++) run_cfg(1, 1, ps, 0);

    // R7 missed compare: write a value below the count before the old one is reached
    wr(2'd0, 16'h0030);
    wr(2'd1, 16'd15);
    wr(2'd2, 16'd10);
    pulse_rst();
    wait_cnt(15);
    @(negedge clk);
    clr_flags(1'b1, 1'b1);
    wait_cnt(6);
    wr(2'd2, 16'd3);
    check("R7 pin still active", 32'(pwm_out), 32'd1);
    wait_cnt(15);
    check("R7 pin active at period end", 32'(pwm_out), 32'd1);
    check("R7 no compare", 32'(cmp_flag), 32'd0);
    check("R10 no cmp irq", 32'(cmp_irq), 32'd0);
    @(negedge clk);
    check("R9 ovf flag set", 32'(ovf_flag), 32'd1);
    check("R10 ovf irq", 32'(ovf_irq), 32'd1);
    wait_cnt(3);
    check("R7 compare next period", 32'(cmp_flag), 32'd1);
    check("R7 pin inactive", 32'(pwm_out), 32'd0);
    check("R10 cmp irq", 32'(cmp_irq), 32'd1);

    // R8 double compare: raise the channel value after the compare
    clr_flags(1'b0, 1'b1);
    wait_cnt(6);
    check("R9 cmp cleared", 32'(cmp_flag), 32'd0);
    wr(2'd2, 16'd10);
    wait_cnt(9);
    check("R8 before second match", 32'(cmp_flag), 32'd0);
    @(negedge clk);
    check("R8 second compare", 32'(cmp_flag), 32'd1);
    check("R8 pin stays inactive", 32'(pwm_out), 32'd0);

    // R10 enables off, flags kept
    wr(2'd0, 16'h0000);
    check("R10 ovf irq gated", 32'({ovf_flag, ovf_irq}), 32'b10);
    check("R10 cmp irq gated", 32'({cmp_flag, cmp_irq}), 32'b10);

    // R9 clear, then set wins over a clear in the same cycle
    clr_flags(1'b1, 1'b0);
    check("R9 ovf cleared", 32'(ovf_flag), 32'd0);
    wait_cnt(15);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R9 set wins", 32'(ovf_flag), 32'd1);
    check("R4 wrap", 32'(cnt_val), 32'd0);

    // R2 a write to select 3 is ignored: modulo 15 and channel 10 still hold
    wr(2'd3, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      check("R2 count", 32'(cnt_val), 32'((i + 1) % 16));
      check("R2 pin", 32'(pwm_out), 32'(int'(cnt_val) < 10));
      @(negedge clk);
    end

    // R4 lower the modulo below the count
    wait_cnt(12);
    wr(2'd1, 16'd5);
    check("R4 count before", 32'(cnt_val), 32'd13);
    @(negedge clk);
    check("R4 over-modulo wrap", 32'(cnt_val), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule